// File: doc/BRIEF.md
# Crystal-Rate Prescaler with Selectable Tick

This block sits at the front of a real-time clock. It runs on the 32768 Hz crystal clock and holds a 10-bit control word that software writes through a single-register write port. A 15-bit free-running divider produces the one-per-second count enable for the calendar counters. A second output is a tick enable whose rate is chosen by a 4-bit code from sixteen power-of-two taps of the same divider. A gated copy of the crystal clock is also driven out of the block.

Three of the control bits only act while the master enable bit is 1: the divider hold, the count-split select and the test-clock select. While the master enable is 0, the block keeps the effective values those three bits had the last time the enable was set. A write permission for the external time-count registers is granted only while the master enable is set. The rate outputs are single-cycle enables in the crystal domain, not derived clocks.

Top module: `rtc_prescaler`

## Requirements
- R1: A write stores `ctl_wdata[9:0]` into the control word. `ctl_rdata` returns that word in bits 9:0 and zero in bits 31:10. Written bits 31:10 are discarded. All 10 bits read back as written, including bits whose effect is currently suppressed. Field positions are: bit 0 master enable, bit 1 test-clock select, bit 2 count-split select, bit 3 divider hold, bits 7:4 tick code, bit 8 tick enable, bit 9 clock-output enable.
- R2: After reset the control word is 0, and `sec_pulse`, `tick_pulse`, `cnt_split`, `cnt_wr_grant` and `clk_out` are all low.
- R3: While the effective divider hold is 1, the divider sits at zero and neither `sec_pulse` (outside test mode) nor `tick_pulse` is asserted. After the write edge that clears the hold, the first `sec_pulse` appears in the cycle that follows the 32768th rising edge.
- R4: While bit 0 is 0, the stored values of bits 1, 2 and 3 are ignored and their previous effective values are kept. Setting bit 0 applies the stored values from the cycle after the write edge.
- R5: With the effective test-clock select at 0, `sec_pulse` is high for one cycle each time the divider wraps from 32767 to 0, which is once per 32768 cycles.
- R6: With the effective test-clock select at 1, `sec_pulse` is high in every cycle, whether or not the divider is held.
- R7: A tick code n gives one `tick_pulse` every 2^n cycles. The first pulse comes 2^n rising edges after the hold is released. Code 0 pulses every cycle and code 15 once per 32768 cycles.
- R8: `tick_pulse` is low in any cycle that follows an edge at which the tick enable bit was 0.
- R9: `clk_out` follows the clock while bit 9 is 1 and is held low otherwise. A change of bit 9 takes effect at a falling clock edge, so no pulse is truncated.
- R10: `cnt_split` shows the effective count-split select.
- R11: `cnt_wr_grant` is high in the cycle after an edge at which `cnt_wr_req` was 1 and the master enable was 1. Otherwise it is low.
- R12: With tick code 15 and the tick enable on, outside test mode, `tick_pulse` and `sec_pulse` assert in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| cnt_wr_req | input | 1 | Request to write the time-count registers |
| cnt_wr_grant | output | 1 | Registered permission for that write |
| sec_pulse | output | 1 | One-per-second count enable (every cycle in test mode) |
| tick_pulse | output | 1 | Selected-rate tick enable |
| cnt_split | output | 1 | Effective count-split select |
| clk_out | output | 1 | Gated crystal clock output |

## Verification
The divider wrap and the slowest tick tap fall on the same edge. When the divider is released with tick code 15 selected, the bench compares the two enables in every one of the following 32768 cycles. It requires that each is low until the 32768th edge and that both are high in that cycle. A lone pulse on either output, or the two pulses landing in different cycles, counts as a failure. A shorter run with tick code 3 then checks that a fast tap keeps its own 8-cycle period and is not tied to the wrap.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
  localparam int CTL_W  = 10;
  localparam int SEL_W  = 4;
  localparam int DIV_W  = 15;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic             clkout_en;
    logic             tick_en;
    logic [SEL_W-1:0] tick_sel;
    logic             div_hold;
    logic             cnt_split;
    logic             clk_test;
    logic             master_en;
  } ctl_t;

  typedef struct packed {
    logic div_hold;
    logic cnt_split;
    logic clk_test;
  } eff_t;
endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl,
  output eff_t              eff,
  output logic [DATA_W-1:0] rdata
);
  ctl_t ctl_q;
  eff_t held_q;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_comb begin
    if (ctl_q.master_en) begin
      eff.div_hold  = ctl_q.div_hold;
      eff.cnt_split = ctl_q.cnt_split;
      eff.clk_test  = ctl_q.clk_test;
    end else begin
      eff = held_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= eff;
  end

  assign ctl   = ctl_q;
  assign rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};

  // R1
  wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rdata[CTL_W-1:0] == $past(wr_data[CTL_W-1:0]));

  // R4
  gated_bits_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.master_en && !$past(ctl_q.master_en)) |-> $stable(eff));
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             test_clk,
  output logic [DIV_W-1:0] cnt,
  output logic             sec_pulse
);
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;
  logic             sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      cnt_q <= hold ? '0 : cnt_q + 1'b1;
      sec_q <= test_clk | (!hold && cnt_q == CNT_MAX);
    end
  end

  assign cnt       = cnt_q;
  assign sec_pulse = sec_q;

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> cnt_q == '0);
endmodule

// File: rtl/rtc_tick_mux.sv
module rtc_tick_mux
  import rtc_pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cnt,
  input  logic             hold,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] tick_sel,
  output logic             tick_pulse
);
  localparam int NTAP = 1 << SEL_W;

  logic [NTAP-1:0] tap;
  logic            tick_q;

  generate
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
      if (g == 0) begin : g_every
        assign tap[g] = 1'b1;
      end else begin : g_div
        assign tap[g] = &cnt[g-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_en && !hold && tap[tick_sel];
  end

  assign tick_pulse = tick_q;

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !tick_pulse);
endmodule

// File: rtl/rtc_clkout_gate.sv
module rtc_clkout_gate (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic clk_out
);
  logic en_low_q;

  always_ff @(negedge clk) begin
    if (rst) en_low_q <= 1'b0;
    else     en_low_q <= enable;
  end

  assign clk_out = clk & en_low_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pre_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        cnt_wr_req,
  output logic        cnt_wr_grant,
  output logic        sec_pulse,
  output logic        tick_pulse,
  output logic        cnt_split,
  output logic        clk_out
);
  ctl_t             ctl;
  eff_t             eff;
  logic [DIV_W-1:0] div_cnt;
  logic             grant_q;

  rtc_ctl_regs u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr),
    .wr_data (ctl_wdata),
    .ctl     (ctl),
    .eff     (eff),
    .rdata   (ctl_rdata)
  );

  rtc_divider u_div (
    .clk       (clk),
    .rst       (rst),
    .hold      (eff.div_hold),
    .test_clk  (eff.clk_test),
    .cnt       (div_cnt),
    .sec_pulse (sec_pulse)
  );

  rtc_tick_mux u_tick (
    .clk        (clk),
    .rst        (rst),
    .cnt        (div_cnt),
    .hold       (eff.div_hold),
    .tick_en    (ctl.tick_en),
    .tick_sel   (ctl.tick_sel),
    .tick_pulse (tick_pulse)
  );

  rtc_clkout_gate u_cko (
    .clk     (clk),
    .rst     (rst),
    .enable  (ctl.clkout_en),
    .clk_out (clk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= cnt_wr_req & ctl.master_en;
  end

  assign cnt_wr_grant = grant_q;
  assign cnt_split    = eff.cnt_split;

  // R12
  slow_tap_align_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.tick_en && ctl.tick_sel == {SEL_W{1'b1}} && !eff.clk_test)
      |=> tick_pulse == sec_pulse);

  // R11
  grant_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.master_en |=> !cnt_wr_grant);
endmodule

// File: tb/rtc_prescaler_tb_top.sv
module rtc_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        cnt_wr_req = 1'b0;
  logic        cnt_wr_grant, sec_pulse, tick_pulse, cnt_split, clk_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rtc_prescaler dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_wr_req(cnt_wr_req), .cnt_wr_grant(cnt_wr_grant),
    .sec_pulse(sec_pulse), .tick_pulse(tick_pulse), .cnt_split(cnt_split),
    .clk_out(clk_out)
  );

  // control word bit helpers: 0 en, 1 test, 2 split, 3 hold, 7:4 code, 8 tick en, 9 clk out
  function automatic logic [31:0] cw(bit en, bit test, bit split, bit hold,
                                     logic [3:0] code, bit ten, bit oe);
    return {22'b0, oe, ten, code, hold, split, test, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // after return the write edge has just passed (sampled 1 ns later)
  task automatic wr_ctl(logic [31:0] d);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_wdata = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R2 rdata", ctl_rdata, 32'h0);
    check("R2 sec", {31'b0, sec_pulse}, 32'h0);
    check("R2 tick", {31'b0, tick_pulse}, 32'h0);
    check("R2 split", {31'b0, cnt_split}, 32'h0);
    check("R2 grant", {31'b0, cnt_wr_grant}, 32'h0);
    check("R2 clk_out", {31'b0, clk_out}, 32'h0);
  endtask

  task automatic t_readback();
    wr_ctl(32'hFFFF_F2A4);
    check("R1 readback", ctl_rdata, 32'h0000_02A4);
    wr_ctl(32'h0000_0000);
    check("R1 clear", ctl_rdata, 32'h0);
  endtask

  task automatic t_gate_by_enable();
    int bad = 0;
    // hold requested but master enable off: divider keeps running, code 0 ticks every cycle
    wr_ctl(cw(0, 0, 1, 1, 4'd0, 1, 0));
    check("R1 suppressed bits read back", ctl_rdata, cw(0, 0, 1, 1, 4'd0, 1, 0));
    step(1);
    for (int i = 0; i < 4; i++) begin
      if (tick_pulse !== 1'b1) bad++;
      step(1);
    end
    check("R4 hold ignored, R7 code 0 every cycle", bad, 0);
    check("R10 split ignored while disabled", {31'b0, cnt_split}, 32'h0);
    wr_ctl(cw(1, 0, 1, 1, 4'd0, 1, 0));
    check("R10 split applied", {31'b0, cnt_split}, 32'h1);
    step(1);
    check("R3 hold stops tick", {31'b0, tick_pulse}, 32'h0);
    wr_ctl(cw(0, 0, 0, 0, 4'd0, 1, 0));
    step(3);
    check("R4 hold kept after disable", {31'b0, tick_pulse}, 32'h0);
    check("R4 split kept after disable", {31'b0, cnt_split}, 32'h1);
    wr_ctl(cw(1, 0, 0, 0, 4'd0, 0, 0));
    step(2);
    check("R8 tick enable off", {31'b0, tick_pulse}, 32'h0);
  endtask

  task automatic t_second_and_slow_tap();
    int first_sec = -1;
    int mismatch = 0;
    int extra = 0;
    wr_ctl(cw(1, 0, 0, 1, 4'd15, 1, 0));
    step(2);
    wr_ctl(cw(1, 0, 0, 0, 4'd15, 1, 0));
    for (int i = 0; i <= 32768; i++) begin
      if (tick_pulse !== sec_pulse) mismatch++;
      if (sec_pulse === 1'b1) begin
        if (first_sec < 0) first_sec = i;
        else extra++;
      end
      if (i != 32768) step(1);
    end
    check("R3 first sec pulse after release", first_sec, 32768);
    check("R5 single pulse per wrap", extra, 0);
    check("R12 tick code 15 aligned with sec", mismatch, 0);
    step(1);
    check("R5 pulse lasts one cycle", {31'b0, sec_pulse}, 32'h0);
  endtask

  task automatic t_fast_tap();
    int first = -1;
    int bad = 0;
    wr_ctl(cw(1, 0, 0, 1, 4'd3, 1, 0));
    step(2);
    wr_ctl(cw(1, 0, 0, 0, 4'd3, 1, 0));
    for (int i = 0; i <= 40; i++) begin
      if (tick_pulse === 1'b1 && first < 0) first = i;
      if (tick_pulse !== ((i != 0 && i % 8 == 0) ? 1'b1 : 1'b0)) bad++;
      if (sec_pulse !== 1'b0) bad++;
      if (i != 40) step(1);
    end
    check("R7 code 3 first tick", first, 8);
    check("R7 code 3 period", bad, 0);
  endtask

  task automatic t_test_mode();
    int bad = 0;
    wr_ctl(cw(1, 1, 0, 1, 4'd0, 0, 0));
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (sec_pulse !== 1'b1) bad++;
    end
    check("R6 test mode sec every cycle", bad, 0);
    wr_ctl(cw(1, 0, 0, 1, 4'd0, 0, 0));
    step(1);
    check("R6 test mode left", {31'b0, sec_pulse}, 32'h0);
  endtask

  task automatic t_grant();
    wr_ctl(cw(0, 0, 0, 0, 4'd0, 0, 0));
    cnt_wr_req = 1'b1;
    step(2);
    check("R11 no grant while disabled", {31'b0, cnt_wr_grant}, 32'h0);
    wr_ctl(cw(1, 0, 0, 0, 4'd0, 0, 0));
    check("R11 grant follows edge", {31'b0, cnt_wr_grant}, 32'h0);
    step(1);
    check("R11 grant while enabled", {31'b0, cnt_wr_grant}, 32'h1);
    cnt_wr_req = 1'b0;
    step(1);
    check("R11 grant drops", {31'b0, cnt_wr_grant}, 32'h0);
  endtask

  task automatic t_clkout();
    wr_ctl(cw(1, 0, 0, 0, 4'd0, 0, 1));
    @(negedge clk); #1;
    check("R9 low phase", {31'b0, clk_out}, 32'h0);
    @(posedge clk); #1;
    check("R9 high phase follows clock", {31'b0, clk_out}, 32'h1);
    wr_ctl(cw(1, 0, 0, 0, 4'd0, 0, 0));
    check("R9 pulse not truncated", {31'b0, clk_out}, 32'h1);
    @(negedge clk); #1;
    @(posedge clk); #1;
    check("R9 disabled held low", {31'b0, clk_out}, 32'h0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset_state();
    t_readback();
    t_gate_by_enable();
    do_reset();
    t_second_and_slow_tap();
    t_fast_tap();
    t_test_mode();
    t_grant();
    t_clkout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule